// File: doc/BRIEF.md
# Two-Point Calibrated Sensor Code Converter

This block turns a raw thermal-sensor ADC code into a whole-degree Celsius reading, and turns a degree value back into an ADC code for programming alarm limits. Each sensor in a small array has its own slope and offset, both in fixed point with a scale factor. The block derives them from two calibration codes, taken at 30 and 120 degrees, when a calibration strobe is given. One-point and uncalibrated modes fall back on a default slope, and the uncalibrated mode also uses a default offset.

All divisions go through one shared sequential signed divider. The block takes a single operation at a time. A calibration load or a conversion request is accepted only while the block is idle. The outcome is reported with a one-cycle `done` pulse and a registered `result` that holds its value until the next pulse. For a conversion the result is the converted value. For a calibration it is the slope that was stored.

Top module: `thermo_code_conv`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A calibration with `cal_mode` 2 or 3 (two-point) stores slope = trunc((code2 − code1) × 1000 / 90) and offset = code1 × 1000 − 30 × slope. Division truncates toward zero, and `result` reports the stored slope.
- R3: A calibration with `cal_mode` 1 (one-point) stores the default slope SLOPE_DEF (3200) and offset = code1 × 1000 − 30 × 3200.
- R4: A calibration with `cal_mode` 0 (uncalibrated) stores the default slope 3200 and the default offset OFF_DEF (500000).
- R5: A two-point calibration whose computed slope is 0 stores the default slope 3200 instead. Its offset then uses 3200, and the reported slope is never 0.
- R6: A forward conversion (`conv_dir` = 0) returns trunc(n′ / slope). Here n = code × 1000 − offset, and n′ = n + trunc(slope/2) when n > 0, otherwise n′ = n − trunc(slope/2).
- R7: A reverse conversion (`conv_dir` = 1) returns trunc((deg × slope + offset) / 1000), clamped to the range 0 to 1023.
- R8: A sensor that has never been calibrated since reset converts with slope 3200 and offset 500000.
- R9: While `busy` is 1, `cal_load` and `conv_req` are ignored. They cause no extra `done`, no change to `result` and no change to stored calibration.
- R10: `done` lasts exactly one cycle, and `result` changes only together with `done`.
- R11: When `cal_load` and `conv_req` arrive in the same idle cycle, the calibration is taken and the conversion is dropped.
- R12: `done` rises DW+2 cycles after the accepting edge for a conversion, DW+1 cycles after it for a two-point calibration, and 1 cycle after it for the other calibration modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_load | input | 1 | Calibration strobe |
| cal_mode | input | 2 | 0 uncalibrated, 1 one-point, 2/3 two-point |
| cal_sel | input | SW | Sensor index to calibrate |
| cal_code1 | input | CODE_W | ADC code at 30 degrees |
| cal_code2 | input | CODE_W | ADC code at 120 degrees |
| conv_req | input | 1 | Conversion request |
| conv_dir | input | 1 | 0 code to degrees, 1 degrees to code |
| conv_sel | input | SW | Sensor index to convert for |
| conv_code | input | CODE_W | ADC code for forward conversion |
| conv_deg | input | DEG_W | Signed degrees for reverse conversion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Signed result: degrees, code, or stored slope |

## Verification
The bench builds the block with two sensors and otherwise default parameters: a 32-bit datapath, 10-bit codes and a scale of 1000. With two sensors, one sensor can stay uncalibrated while the other is loaded. The 10-bit code space is small enough that every forward code is swept against both a rising and a falling two-point calibration. That sweep covers both rounding branches and both signs of the divisor. A degree sweep from −100 to 300 drives reverse conversion into both clamp limits.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALW  = 2'd1,
    ST_FETCH = 2'd2,
    ST_DIV   = 2'd3
  } tcc_state_t;

  typedef enum logic [1:0] {
    OP_CAL = 2'd0,
    OP_FWD = 2'd1,
    OP_REV = 2'd2
  } tcc_op_t;
endpackage

// File: rtl/tcc_seq_div.sv
module tcc_seq_div #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [DW-1:0] dividend,
  input  logic signed [DW-1:0] divisor,
  output logic                 done,
  output logic signed [DW-1:0] quotient
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q, dvs_q, rem_q;
  logic          neg_q, run_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] a_abs, b_abs;
  logic [DW:0]   part;
  logic [DW+1:0] trial;
  logic          fits;

  assign a_abs = dividend[DW-1] ? DW'(-dividend) : DW'(dividend);
  assign b_abs = divisor[DW-1]  ? DW'(-divisor)  : DW'(divisor);
  assign part  = {rem_q, quo_q[DW-1]};
  assign trial = {1'b0, part} - {2'b00, dvs_q};
  assign fits  = ~trial[DW+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
      neg_q <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo_q <= a_abs;
        dvs_q <= b_abs;
        rem_q <= '0;
        neg_q <= dividend[DW-1] ^ divisor[DW-1];
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) begin
          rem_q <= trial[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= part[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = neg_q ? -$signed(quo_q) : $signed(quo_q);
endmodule

// File: rtl/tcc_cal_store.sv
module tcc_cal_store #(
  parameter int NS = 4,
  parameter int DW = 32,
  parameter int SW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SW-1:0]        waddr,
  input  logic signed [DW-1:0] wslope,
  input  logic signed [DW-1:0] woff,
  input  logic [SW-1:0]        raddr,
  output logic                 rvalid,
  output logic signed [DW-1:0] rslope,
  output logic signed [DW-1:0] roff
);
  logic [2*DW-1:0] mem [NS];
  logic [NS-1:0]   vld_q;
  logic [2*DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wslope, woff};
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) vld_q[waddr] <= 1'b1;
      rvalid <= vld_q[raddr] & ~(we && waddr == raddr);
    end
  end

  assign rslope = $signed(rd_q[2*DW-1:DW]);
  assign roff   = $signed(rd_q[DW-1:0]);
endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv
  import tcc_pkg::*;
#(
  parameter int NS        = 4,
  parameter int CODE_W    = 10,
  parameter int DEG_W     = 10,
  parameter int DW        = 32,
  parameter int SCALE     = 1000,
  parameter int DEG_LO    = 30,
  parameter int DEG_HI    = 120,
  parameter int SLOPE_DEF = 3200,
  parameter int OFF_DEF   = 500000,
  parameter int CODE_MIN  = 0,
  parameter int CODE_MAX  = (1 << CODE_W) - 1,
  parameter int SW        = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cal_load,
  input  logic [1:0]              cal_mode,
  input  logic [SW-1:0]           cal_sel,
  input  logic [CODE_W-1:0]       cal_code1,
  input  logic [CODE_W-1:0]       cal_code2,
  input  logic                    conv_req,
  input  logic                    conv_dir,
  input  logic [SW-1:0]           conv_sel,
  input  logic [CODE_W-1:0]       conv_code,
  input  logic signed [DEG_W-1:0] conv_deg,
  output logic                    busy,
  output logic                    done,
  output logic signed [DW-1:0]    result
);
  localparam logic signed [DW-1:0] SCALE_S = DW'(SCALE);
  localparam logic signed [DW-1:0] SPAN_S  = DW'(DEG_HI - DEG_LO);
  localparam logic signed [DW-1:0] LO_S    = DW'(DEG_LO);
  localparam logic signed [DW-1:0] SLOPE_S = DW'(SLOPE_DEF);
  localparam logic signed [DW-1:0] OFF_S   = DW'(OFF_DEF);
  localparam logic signed [DW-1:0] MIN_S   = DW'(CODE_MIN);
  localparam logic signed [DW-1:0] MAX_S   = DW'(CODE_MAX);

  tcc_state_t st_q;
  tcc_op_t    op_q;
  logic [SW-1:0]        sel_q;
  logic [1:0]           mode_q;
  logic signed [DW-1:0] c1_q, code_q, deg_q;

  logic take_cal, take_cnv;
  logic signed [DW-1:0] c1_ext, c2_ext, code_ext, deg_ext;

  logic                 st_vld;
  logic signed [DW-1:0] st_slope, st_off;
  logic signed [DW-1:0] eff_slope, eff_off, half_slope;
  logic signed [DW-1:0] fwd_raw, fwd_num, rev_num;

  logic                 dv_start, dv_done;
  logic signed [DW-1:0] dv_num, dv_den, dv_q;

  logic signed [DW-1:0] cal_slope, cal_off, clamped;
  logic                 st_we;

  assign take_cal = (st_q == ST_IDLE) && cal_load;
  assign take_cnv = (st_q == ST_IDLE) && !cal_load && conv_req;

  assign c1_ext   = $signed({{(DW-CODE_W){1'b0}}, cal_code1});
  assign c2_ext   = $signed({{(DW-CODE_W){1'b0}}, cal_code2});
  assign code_ext = $signed({{(DW-CODE_W){1'b0}}, conv_code});
  assign deg_ext  = DW'(conv_deg);

  tcc_cal_store #(.NS(NS), .DW(DW), .SW(SW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (st_we),
    .waddr  (sel_q),
    .wslope (cal_slope),
    .woff   (cal_off),
    .raddr  ((st_q == ST_IDLE) ? conv_sel : sel_q),
    .rvalid (st_vld),
    .rslope (st_slope),
    .roff   (st_off)
  );

  assign eff_slope  = st_vld ? st_slope : SLOPE_S;
  assign eff_off    = st_vld ? st_off   : OFF_S;
  assign half_slope = (eff_slope + (eff_slope[DW-1] ? DW'(1) : DW'(0))) >>> 1;
  assign fwd_raw    = code_q * SCALE_S - eff_off;
  assign fwd_num    = (fwd_raw > 0) ? fwd_raw + half_slope : fwd_raw - half_slope;
  assign rev_num    = deg_q * eff_slope + eff_off;

  always_comb begin
    dv_start = 1'b0;
    dv_num   = '0;
    dv_den   = SPAN_S;
    if (st_q == ST_IDLE) begin
      dv_start = take_cal && cal_mode[1];
      dv_num   = (c2_ext - c1_ext) * SCALE_S;
    end else if (st_q == ST_FETCH) begin
      dv_start = 1'b1;
      if (op_q == OP_FWD) begin
        dv_num = fwd_num;
        dv_den = eff_slope;
      end else begin
        dv_num = rev_num;
        dv_den = SCALE_S;
      end
    end
  end

  tcc_seq_div #(.DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (dv_start),
    .dividend (dv_num),
    .divisor  (dv_den),
    .done     (dv_done),
    .quotient (dv_q)
  );

  assign cal_slope = (st_q == ST_CALW || dv_q == '0) ? SLOPE_S : dv_q;
  assign cal_off   = (mode_q == 2'd0) ? OFF_S : c1_q * SCALE_S - LO_S * cal_slope;
  assign st_we     = (st_q == ST_CALW) || (st_q == ST_DIV && op_q == OP_CAL && dv_done);
  assign clamped   = (dv_q < MIN_S) ? MIN_S : ((dv_q > MAX_S) ? MAX_S : dv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CAL;
      sel_q  <= '0;
      mode_q <= '0;
      c1_q   <= '0;
      code_q <= '0;
      deg_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take_cal) begin
            op_q   <= OP_CAL;
            sel_q  <= cal_sel;
            mode_q <= cal_mode;
            c1_q   <= c1_ext;
            st_q   <= cal_mode[1] ? ST_DIV : ST_CALW;
          end else if (take_cnv) begin
            op_q   <= conv_dir ? OP_REV : OP_FWD;
            sel_q  <= conv_sel;
            code_q <= code_ext;
            deg_q  <= deg_ext;
            st_q   <= ST_FETCH;
          end
        end
        ST_CALW: begin
          done   <= 1'b1;
          result <= cal_slope;
          st_q   <= ST_IDLE;
        end
        ST_FETCH: st_q <= ST_DIV;
        ST_DIV: begin
          if (dv_done) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
            case (op_q)
              OP_CAL:  result <= cal_slope;
              OP_FWD:  result <= dv_q;
              default: result <= clamped;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int DW       = 32,
  parameter int CODE_MIN = 0,
  parameter int CODE_MAX = 1023
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cal_load,
  input logic                 conv_req,
  input logic                 conv_dir,
  input logic                 busy,
  input logic                 done,
  input logic signed [DW-1:0] result
);
  logic cal_q, rev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= 1'b0;
      rev_q <= 1'b0;
    end else if (!busy && cal_load) begin
      cal_q <= 1'b1;
      rev_q <= 1'b0;
    end else if (!busy && conv_req) begin
      cal_q <= 1'b0;
      rev_q <= conv_dir;
    end
  end

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && (cal_load || conv_req)) |=> busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cal_load && !conv_req) |=> (!busy && !done));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_rev_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (done && rev_q && !cal_q) |-> (result >= DW'(CODE_MIN) && result <= DW'(CODE_MAX)));

  p_slope_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && cal_q) |-> (result != '0));
endmodule

bind thermo_code_conv tcc_checker #(
  .DW(DW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cal_load (cal_load),
  .conv_req (conv_req),
  .conv_dir (conv_dir),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/sim_thermo_code_conv.sv
module sim_thermo_code_conv;
  localparam int NS = 2;
  localparam int SW = 1;
  localparam int DW = 32;
  localparam int SDEF = 3200;
  localparam int ODEF = 500000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_load = 1'b0;
  logic [1:0] cal_mode = '0;
  logic [SW-1:0] cal_sel = '0;
  logic [9:0] cal_code1 = '0, cal_code2 = '0;
  logic conv_req = 1'b0, conv_dir = 1'b0;
  logic [SW-1:0] conv_sel = '0;
  logic [9:0] conv_code = '0;
  logic signed [9:0] conv_deg = '0;
  logic busy, done;
  logic signed [DW-1:0] result;

  int checks = 0, fails = 0;
  int m_slope [NS];
  int m_off [NS];
  bit finished = 0;

  always #4 clk = ~clk;

  thermo_code_conv #(.NS(NS)) u0 (
    .clk(clk), .rst(rst), .cal_load(cal_load), .cal_mode(cal_mode),
    .cal_sel(cal_sel), .cal_code1(cal_code1), .cal_code2(cal_code2),
    .conv_req(conv_req), .conv_dir(conv_dir), .conv_sel(conv_sel),
    .conv_code(conv_code), .conv_deg(conv_deg),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_fwd(input int s, input int o, input int code);
    int n;
    n = code * 1000 - o;
    n = (n > 0) ? n + s / 2 : n - s / 2;
    return n / s;
  endfunction

  function automatic int e_rev(input int s, input int o, input int deg);
    int v;
    v = (deg * s + o) / 1000;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic issue(output int res, output int lat);
    int n;
    bit got;
    n = 0; got = 0; res = 0;
    @(posedge clk); n = 1;
    #1 cal_load = 1'b0; conv_req = 1'b0;
    while (!got && n < 200) begin
      @(negedge clk);
      if (done) begin got = 1; res = result; end
      else begin @(posedge clk); n++; end
    end
    if (!got) chk(0, "R12 op timeout", n, 0);
    lat = n - 1;
  endtask

  task automatic do_cal(input int sel, input int mode, input int c1, input int c2,
                        output int res, output int lat);
    int s, o;
    cal_load = 1'b1; cal_mode = 2'(mode); cal_sel = SW'(sel);
    cal_code1 = 10'(c1); cal_code2 = 10'(c2);
    issue(res, lat);
    if (mode >= 2) begin
      s = ((c2 - c1) * 1000) / 90;
      if (s == 0) s = SDEF;
    end else s = SDEF;
    o = (mode == 0) ? ODEF : c1 * 1000 - 30 * s;
    m_slope[sel] = s; m_off[sel] = o;
  endtask

  task automatic do_fwd(input int sel, input int code, output int res, output int lat);
    conv_req = 1'b1; conv_dir = 1'b0; conv_sel = SW'(sel); conv_code = 10'(code);
    issue(res, lat);
  endtask

  task automatic do_rev(input int sel, input int deg, output int res, output int lat);
    conv_req = 1'b1; conv_dir = 1'b1; conv_sel = SW'(sel); conv_deg = 10'(deg);
    issue(res, lat);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r, l, e, cnt, held;
    for (int i = 0; i < NS; i++) begin m_slope[i] = SDEF; m_off[i] = ODEF; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(result == 0, "R1 result", result, 0);

    // R8: never-calibrated sensor uses defaults
    foreach (m_slope[i]) begin end
    do_fwd(1, 512, r, l);
    chk(r == e_fwd(SDEF, ODEF, 512), "R8 fwd default", r, e_fwd(SDEF, ODEF, 512));
    chk(l == DW + 2, "R12 conversion latency", l, DW + 2);
    do_rev(1, 40, r, l);
    chk(r == e_rev(SDEF, ODEF, 40), "R8 rev default", r, e_rev(SDEF, ODEF, 40));

    // R2: two-point rising calibration
    do_cal(0, 2, 300, 600, r, l);
    chk(r == 3333, "R2 slope", r, 3333);
    chk(l == DW + 1, "R12 two-point latency", l, DW + 1);

    // R6: full forward sweep, both rounding branches
    for (int c = 0; c < 1024; c++) begin
      do_fwd(0, c, r, l);
      e = e_fwd(m_slope[0], m_off[0], c);
      chk(r == e, "R6 forward rising", r, e);
    end

    // R7: reverse sweep with both clamps
    for (int d = -100; d <= 300; d++) begin
      do_rev(0, d, r, l);
      e = e_rev(m_slope[0], m_off[0], d);
      chk(r == e, "R7 reverse clamp", r, e);
    end

    // R2/R6: falling calibration, negative slope
    do_cal(1, 3, 700, 400, r, l);
    chk(r == -3333, "R2 negative slope", r, -3333);
    for (int c = 0; c < 1024; c++) begin
      do_fwd(1, c, r, l);
      e = e_fwd(m_slope[1], m_off[1], c);
      chk(r == e, "R6 forward falling", r, e);
    end

    // R3: one-point
    do_cal(1, 1, 400, 0, r, l);
    chk(r == SDEF, "R3 slope", r, SDEF);
    chk(l == 1, "R12 one-point latency", l, 1);
    for (int c = 300; c < 1024; c += 97) begin
      do_fwd(1, c, r, l);
      e = e_fwd(SDEF, 400 * 1000 - 30 * SDEF, c);
      chk(r == e, "R3 one-point forward", r, e);
    end

    // R4: uncalibrated
    do_cal(1, 0, 900, 100, r, l);
    chk(r == SDEF, "R4 slope", r, SDEF);
    for (int c = 100; c < 1024; c += 211) begin
      do_fwd(1, c, r, l);
      e = e_fwd(SDEF, ODEF, c);
      chk(r == e, "R4 uncalibrated forward", r, e);
    end

    // R5: zero computed slope
    do_cal(1, 2, 500, 500, r, l);
    chk(r == SDEF, "R5 zero slope replaced", r, SDEF);
    do_fwd(1, 700, r, l);
    e = e_fwd(SDEF, 500 * 1000 - 30 * SDEF, 700);
    chk(r == e, "R5 offset from default slope", r, e);

    // R9: requests while busy are ignored
    conv_req = 1'b1; conv_dir = 1'b0; conv_sel = 0; conv_code = 10'd700;
    @(posedge clk);
    #1 conv_req = 1'b0;
    @(negedge clk);
    chk(busy == 1, "R9 busy after accept", busy, 1);
    cal_load = 1'b1; cal_mode = 2'd0; cal_sel = 0;
    conv_req = 1'b1; conv_code = 10'd100;
    repeat (3) @(negedge clk);
    cal_load = 1'b0; conv_req = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    e = e_fwd(m_slope[0], m_off[0], 700);
    chk(result == e, "R9 first result kept", result, e);
    // R10: one-cycle pulse, result held
    held = result;
    cnt = 0;
    for (int k = 0; k < DW + 6; k++) begin
      @(negedge clk);
      if (done) cnt++;
      if (result != held) cnt += 100;
    end
    chk(cnt == 0, "R9 R10 no extra done, result held", cnt, 0);
    do_fwd(0, 700, r, l);
    chk(r == e, "R9 calibration unchanged", r, e);

    // R11: simultaneous load and request
    cal_load = 1'b1; cal_mode = 2'd1; cal_sel = 0; cal_code1 = 10'd350;
    conv_req = 1'b1; conv_dir = 1'b0; conv_sel = 0; conv_code = 10'd500;
    issue(r, l);
    chk(r == SDEF && l == 1, "R11 calibration wins", r, SDEF);
    @(negedge clk);
    chk(done == 0, "R11 conversion dropped", done, 0);
    do_fwd(0, 500, r, l);
    e = e_fwd(SDEF, 350 * 1000 - 30 * SDEF, 500);
    chk(r == e, "R11 new calibration applied", r, e);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule